// File: doc/BRIEF.md
# Store Buffer with Fence and Exception Drain

This block sits between a core's store execution pipeline and a cache write port. A store reserves a slot at allocation time, in program order, before its address or data exists. The returned slot tag is later used by two independent write ports, one for the address and one for the data, which may arrive in either order. A slot is complete only when both halves have arrived. Stores leave the buffer strictly oldest-first through a valid/ready cache port. A store is removed only when the cache accepts it, and that acceptance is the point at which it becomes globally visible.

The buffer drains lazily. It offers its head slot to the cache only while a drain trigger is active: a pending fence that still has older stores outstanding, a pending exception, or a full buffer. Three fence kinds share one handshake:
- A store fence completes once every store present at its acceptance has committed. Loads keep running while it is pending.
- A full fence drains the same way and also holds back loads until it completes.
- A serialization request behaves like a full fence.

An exception lets the complete slots at the head commit, then discards everything from the first incomplete slot onward. A combinational lookup lets a younger load pick up data from the youngest matching buffered store.

Top module: `store_drain_buf`

## Requirements
- R1: Allocation returns slot tags in program order: the slot index increases by one per accepted allocation and wraps modulo DEPTH. `alloc_ready` is low while DEPTH slots are occupied or an exception is pending.
- R2: Address and data writes to an allocated slot are accepted in either order. A second write of the same field to an occupied slot is ignored, and so is a write to a slot that is not occupied.
- R3: Commits leave in allocation order, one per cycle in which `cache_valid` and `cache_ready` are both high. An incomplete head slot blocks every younger complete slot.
- R4: `cache_valid` is high only while a drain trigger is active: a pending fence with older stores outstanding, a pending exception, or all DEPTH slots occupied. A full-buffer drain stops as soon as one slot has left.
- R5: While `cache_valid` is high and `cache_ready` is low, the next cycle keeps `cache_valid` high with `cache_addr` and `cache_data` unchanged.
- R6: `fence_kind` 0 selects a store fence. It is accepted when `fence_valid` and `fence_ready` are both high. `fence_done` pulses for one cycle once all stores present at acceptance have committed. Loads are not stalled by it.
- R7: `fence_kind` 1 selects a full fence, and kinds 2 and 3 select serialization. Both drain like R6 and also force `ld_stall` high, from the cycle after acceptance through the `fence_done` cycle.
- R8: A load address that exactly equals the address of one or more buffered stores returns `ld_hit` with the data of the youngest such store, provided that store has its data.
- R9: A load reports `ld_stall` when any buffered slot still lacks its address, or when the youngest matching slot lacks its data. With all addresses known and no match, both `ld_hit` and `ld_stall` are low.
- R10: After an `exc_req` pulse, complete head slots keep committing. When the head is incomplete or the buffer is empty, all remaining slots are discarded and `exc_done` pulses. The next allocation reuses the slot after the last committed one.
- R11: A synchronous reset empties the buffer, clears pending fences and exceptions, and returns tag 0 as the next allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | Request to reserve a slot |
| alloc_ready | output | 1 | A slot can be reserved this cycle |
| alloc_tag | output | log2(DEPTH) | Tag of the slot reserved on handshake |
| addr_wr_valid | input | 1 | Address write strobe |
| addr_wr_tag | input | log2(DEPTH) | Slot receiving the address |
| addr_wr_value | input | AW | Store address |
| data_wr_valid | input | 1 | Data write strobe |
| data_wr_tag | input | log2(DEPTH) | Slot receiving the data |
| data_wr_value | input | DW | Store data |
| cache_valid | output | 1 | Head store offered to the cache |
| cache_ready | input | 1 | Cache accepts the offered store |
| cache_addr | output | AW | Address of the offered store |
| cache_data | output | DW | Data of the offered store |
| ld_valid | input | 1 | Forwarding lookup request |
| ld_addr | input | AW | Load address |
| ld_hit | output | 1 | Forwarded data is valid |
| ld_stall | output | 1 | Load must wait |
| ld_data | output | DW | Forwarded data |
| fence_valid | input | 1 | Fence request |
| fence_kind | input | 2 | 0 store fence, 1 full fence, 2 or 3 serialization |
| fence_ready | output | 1 | No fence pending; a new one can be accepted |
| fence_done | output | 1 | One-cycle completion pulse of the pending fence |
| exc_req | input | 1 | Exception flush request pulse |
| exc_done | output | 1 | One-cycle pulse when the exception flush occurs |

## Verification
Corrupted ring pointers or fill bits surface at the cache port within a single commit. The scoreboard compares each accepted address and data against the slot expected in program order, so a skipped, repeated or reordered slot fails on its first handshake. A wrong fence count shows up as a `fence_done` pulse that arrives before the commit count reaches the number of older stores, or one that never arrives. A forwarding fault is visible in the same cycle as the probe, through the hit, stall and data outputs, under youngest-match, missing-data and unknown-address patterns.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
   typedef enum logic [1:0] {
      FK_STORE  = 2'd0,
      FK_FULL   = 2'd1,
      FK_SER_A  = 2'd2,
      FK_SER_B  = 2'd3
   } fence_kind_e;

   function automatic logic kind_blocks_loads(input fence_kind_e k);
      return k != FK_STORE;
   endfunction
endpackage

// File: rtl/sb_ring_ptr.sv
module sb_ring_ptr #(
   parameter int DEPTH = 8,
   localparam int IW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic          pop,
   input  logic          flush,
   output logic [IW-1:0] head,
   output logic [IW-1:0] tail,
   output logic [CW-1:0] occ,
   output logic          full
);
   always_ff @(posedge clk) begin
      if (rst) begin
         head <= '0;
         tail <= '0;
         occ  <= '0;
      end else if (flush) begin
         tail <= head;
         occ  <= '0;
      end else begin
         if (push) tail <= tail + 1'b1;
         if (pop)  head <= head + 1'b1;
         occ <= occ + CW'(push) - CW'(pop);
      end
   end

   assign full = (occ == CW'(DEPTH));
endmodule

// File: rtl/sb_entry_bank.sv
module sb_entry_bank #(
   parameter int DEPTH = 8,
   parameter int AW = 32,
   parameter int DW = 32,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   flush,
   input  logic                   alloc_fire,
   input  logic [IW-1:0]          alloc_idx,
   input  logic                   pop,
   input  logic [IW-1:0]          pop_idx,
   input  logic                   a_we,
   input  logic [IW-1:0]          a_idx,
   input  logic [AW-1:0]          a_val,
   input  logic                   d_we,
   input  logic [IW-1:0]          d_idx,
   input  logic [DW-1:0]          d_val,
   output logic [DEPTH-1:0]       a_ok,
   output logic [DEPTH-1:0]       d_ok,
   output logic [DEPTH-1:0][AW-1:0] addr_q,
   output logic [DEPTH-1:0][DW-1:0] data_q
);
   logic [DEPTH-1:0] busy;

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      logic take_a, take_d;
      assign take_a = a_we && (a_idx == IW'(e)) && busy[e] && !a_ok[e];
      assign take_d = d_we && (d_idx == IW'(e)) && busy[e] && !d_ok[e];

      always_ff @(posedge clk) begin
         if (rst || flush) begin
            busy[e] <= 1'b0;
            a_ok[e] <= 1'b0;
            d_ok[e] <= 1'b0;
         end else if (alloc_fire && alloc_idx == IW'(e)) begin
            busy[e] <= 1'b1;
            a_ok[e] <= 1'b0;
            d_ok[e] <= 1'b0;
         end else if (pop && pop_idx == IW'(e)) begin
            busy[e] <= 1'b0;
            a_ok[e] <= 1'b0;
            d_ok[e] <= 1'b0;
         end else begin
            if (take_a) a_ok[e] <= 1'b1;
            if (take_d) d_ok[e] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (take_a) addr_q[e] <= a_val;
         if (take_d) data_q[e] <= d_val;
      end
   end
endmodule

// File: rtl/sb_fwd_lookup.sv
module sb_fwd_lookup #(
   parameter int DEPTH = 8,
   parameter int AW = 32,
   parameter int DW = 32,
   localparam int IW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic                     ld_valid,
   input  logic [AW-1:0]            ld_addr,
   input  logic                     ld_block,
   input  logic [IW-1:0]            head,
   input  logic [CW-1:0]            occ,
   input  logic [DEPTH-1:0]         a_ok,
   input  logic [DEPTH-1:0]         d_ok,
   input  logic [DEPTH-1:0][AW-1:0] addr_q,
   input  logic [DEPTH-1:0][DW-1:0] data_q,
   output logic                     ld_hit,
   output logic                     ld_stall,
   output logic [DW-1:0]            ld_data
);
   logic          unknown, match, match_dok;
   logic [DW-1:0] match_data;

   // Walk oldest to youngest; later matches override earlier ones.
   always_comb begin
      logic [IW-1:0] idx;
      unknown    = 1'b0;
      match      = 1'b0;
      match_dok  = 1'b0;
      match_data = '0;
      idx        = head;
      for (int i = 0; i < DEPTH; i++) begin
         idx = head + IW'(i);
         if (CW'(i) < occ) begin
            if (!a_ok[idx]) begin
               unknown = 1'b1;
            end else if (addr_q[idx] == ld_addr) begin
               match      = 1'b1;
               match_dok  = d_ok[idx];
               match_data = data_q[idx];
            end
         end
      end
   end

   assign ld_stall = ld_valid && (ld_block || unknown || (match && !match_dok));
   assign ld_hit   = ld_valid && !ld_stall && match;
   assign ld_data  = match_data;
endmodule

// File: rtl/sb_drain_ctrl.sv
module sb_drain_ctrl
   import sbuf_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          fence_valid,
   input  logic [1:0]    fence_kind,
   input  logic          exc_req,
   input  logic [CW-1:0] occ,
   input  logic          full,
   input  logic          head_ready,
   input  logic          commit_fire,
   output logic          fence_ready,
   output logic          fence_done,
   output logic          ld_block,
   output logic          exc_pend,
   output logic          flush,
   output logic          drain
);
   logic          fence_pend;
   fence_kind_e   kind_q;
   logic [CW-1:0] older_cnt;
   logic          fence_fire;

   assign fence_ready = !fence_pend;
   assign fence_fire  = fence_valid && fence_ready;
   assign fence_done  = fence_pend && (older_cnt == '0);
   assign ld_block    = fence_pend && kind_blocks_loads(kind_q);
   assign flush       = exc_pend && !head_ready;
   assign drain       = (fence_pend && older_cnt != '0) || exc_pend || full;

   always_ff @(posedge clk) begin
      if (rst) begin
         fence_pend <= 1'b0;
         kind_q     <= FK_STORE;
         older_cnt  <= '0;
         exc_pend   <= 1'b0;
      end else begin
         exc_pend <= (exc_pend && !flush) || exc_req;
         if (fence_fire) begin
            fence_pend <= 1'b1;
            kind_q     <= fence_kind_e'(fence_kind);
            older_cnt  <= occ - CW'(commit_fire);
         end else if (fence_done) begin
            fence_pend <= 1'b0;
         end else if (fence_pend) begin
            if (flush)            older_cnt <= '0;
            else if (commit_fire) older_cnt <= older_cnt - 1'b1;
         end
      end
   end
endmodule

// File: rtl/store_drain_buf.sv
module store_drain_buf #(
   parameter int DEPTH = 8,
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       alloc_valid,
   output logic                       alloc_ready,
   output logic [$clog2(DEPTH)-1:0]   alloc_tag,
   input  logic                       addr_wr_valid,
   input  logic [$clog2(DEPTH)-1:0]   addr_wr_tag,
   input  logic [AW-1:0]              addr_wr_value,
   input  logic                       data_wr_valid,
   input  logic [$clog2(DEPTH)-1:0]   data_wr_tag,
   input  logic [DW-1:0]              data_wr_value,
   output logic                       cache_valid,
   input  logic                       cache_ready,
   output logic [AW-1:0]              cache_addr,
   output logic [DW-1:0]              cache_data,
   input  logic                       ld_valid,
   input  logic [AW-1:0]              ld_addr,
   output logic                       ld_hit,
   output logic                       ld_stall,
   output logic [DW-1:0]              ld_data,
   input  logic                       fence_valid,
   input  logic [1:0]                 fence_kind,
   output logic                       fence_ready,
   output logic                       fence_done,
   input  logic                       exc_req,
   output logic                       exc_done
);
   localparam int IW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("AW and DW must be positive");
   end

   logic [IW-1:0]            head, tail;
   logic [CW-1:0]            occ;
   logic                     full, flush, drain, exc_pend, ld_block;
   logic                     alloc_fire, commit_fire, head_ready;
   logic [DEPTH-1:0]         a_ok, d_ok;
   logic [DEPTH-1:0][AW-1:0] addr_q;
   logic [DEPTH-1:0][DW-1:0] data_q;

   assign alloc_ready = !full && !exc_pend;
   assign alloc_fire  = alloc_valid && alloc_ready;
   assign alloc_tag   = tail;
   assign head_ready  = (occ != '0) && a_ok[head] && d_ok[head];
   assign cache_valid = drain && head_ready;
   assign commit_fire = cache_valid && cache_ready;
   assign cache_addr  = addr_q[head];
   assign cache_data  = data_q[head];
   assign exc_done    = flush;

   sb_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk(clk), .rst(rst), .push(alloc_fire), .pop(commit_fire), .flush(flush),
      .head(head), .tail(tail), .occ(occ), .full(full)
   );

   sb_entry_bank #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_bank (
      .clk(clk), .rst(rst), .flush(flush),
      .alloc_fire(alloc_fire), .alloc_idx(tail),
      .pop(commit_fire), .pop_idx(head),
      .a_we(addr_wr_valid), .a_idx(addr_wr_tag), .a_val(addr_wr_value),
      .d_we(data_wr_valid), .d_idx(data_wr_tag), .d_val(data_wr_value),
      .a_ok(a_ok), .d_ok(d_ok), .addr_q(addr_q), .data_q(data_q)
   );

   sb_fwd_lookup #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
      .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_block(ld_block),
      .head(head), .occ(occ), .a_ok(a_ok), .d_ok(d_ok),
      .addr_q(addr_q), .data_q(data_q),
      .ld_hit(ld_hit), .ld_stall(ld_stall), .ld_data(ld_data)
   );

   sb_drain_ctrl #(.DEPTH(DEPTH)) u_drain (
      .clk(clk), .rst(rst), .fence_valid(fence_valid), .fence_kind(fence_kind),
      .exc_req(exc_req), .occ(occ), .full(full), .head_ready(head_ready),
      .commit_fire(commit_fire), .fence_ready(fence_ready), .fence_done(fence_done),
      .ld_block(ld_block), .exc_pend(exc_pend), .flush(flush), .drain(drain)
   );
endmodule

// File: rtl/sb_check.sv
module sb_check #(
   parameter int DEPTH = 8,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst,
   input logic [CW-1:0] occ,
   input logic          full,
   input logic          exc_pend,
   input logic          alloc_valid,
   input logic          alloc_ready,
   input logic          cache_valid,
   input logic          cache_ready,
   input logic [31:0]   cache_addr_lo,
   input logic [31:0]   cache_data_lo,
   input logic          ld_valid,
   input logic          ld_hit,
   input logic          ld_stall,
   input logic          fence_valid,
   input logic [1:0]    fence_kind,
   input logic          fence_ready,
   input logic          fence_done,
   input logic          exc_done
);
   p_occ_bound_r1: assert property (@(posedge clk) disable iff (rst)
      occ <= CW'(DEPTH));

   p_full_noalloc_r1: assert property (@(posedge clk) disable iff (rst)
      occ == CW'(DEPTH) |-> !alloc_ready);

   p_commit_dec_r3: assert property (@(posedge clk) disable iff (rst)
      (cache_valid && cache_ready && !(alloc_valid && alloc_ready))
      |=> occ == CW'($past(occ) - 1'b1));

   p_trigger_r4: assert property (@(posedge clk) disable iff (rst)
      cache_valid |-> (full || !fence_ready || exc_pend));

   p_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (cache_valid && !cache_ready)
      |=> cache_valid && $stable(cache_addr_lo) && $stable(cache_data_lo));

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      fence_done |=> !fence_done && fence_ready);

   p_block_r7: assert property (@(posedge clk) disable iff (rst)
      (fence_valid && fence_ready && fence_kind != 2'd0) |=> (!ld_valid || ld_stall));

   p_hit_excl_r9: assert property (@(posedge clk) disable iff (rst)
      !(ld_hit && ld_stall));

   p_flush_empty_r10: assert property (@(posedge clk) disable iff (rst)
      exc_done |=> occ == '0);
endmodule

bind store_drain_buf sb_check #(.DEPTH(DEPTH)) u_sb_check (
   .clk(clk), .rst(rst), .occ(occ), .full(full), .exc_pend(exc_pend),
   .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
   .cache_valid(cache_valid), .cache_ready(cache_ready),
   .cache_addr_lo(32'(cache_addr)), .cache_data_lo(32'(cache_data)),
   .ld_valid(ld_valid), .ld_hit(ld_hit), .ld_stall(ld_stall),
   .fence_valid(fence_valid), .fence_kind(fence_kind),
   .fence_ready(fence_ready), .fence_done(fence_done), .exc_done(exc_done)
);

// File: tb/store_drain_buf_bench.sv
`timescale 1ns/1ps
module store_drain_buf_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        alloc_valid = 0, addr_wr_valid = 0, data_wr_valid = 0;
   logic        cache_ready = 1, ld_valid = 0, fence_valid = 0, exc_req = 0;
   logic [2:0]  addr_wr_tag = 0, data_wr_tag = 0;
   logic [31:0] addr_wr_value = 0, data_wr_value = 0, ld_addr = 0;
   logic [1:0]  fence_kind = 0;
   logic        alloc_ready, cache_valid, ld_hit, ld_stall;
   logic        fence_ready, fence_done, exc_done;
   logic [2:0]  alloc_tag;
   logic [31:0] cache_addr, cache_data, ld_data;

   int n_checks = 0, n_errors = 0, n_commits = 0;
   bit finished = 0;
   logic [31:0] exp_addr [8];
   logic [31:0] exp_data [8];
   int order_q[$];

   always #2.5 clk = ~clk;

   store_drain_buf u_store_drain_buf (
      .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
      .alloc_tag(alloc_tag), .addr_wr_valid(addr_wr_valid), .addr_wr_tag(addr_wr_tag),
      .addr_wr_value(addr_wr_value), .data_wr_valid(data_wr_valid),
      .data_wr_tag(data_wr_tag), .data_wr_value(data_wr_value),
      .cache_valid(cache_valid), .cache_ready(cache_ready), .cache_addr(cache_addr),
      .cache_data(cache_data), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_hit(ld_hit),
      .ld_stall(ld_stall), .ld_data(ld_data), .fence_valid(fence_valid),
      .fence_kind(fence_kind), .fence_ready(fence_ready), .fence_done(fence_done),
      .exc_req(exc_req), .exc_done(exc_done)
   );

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic do_alloc(input int exp_tag);
      alloc_valid = 1;
      #0.1;
      chk(alloc_ready === 1'b1, "R1 alloc_ready before allocation", 32'(alloc_ready), 1);
      chk(alloc_tag === 3'(exp_tag), "R1 program-order tag", 32'(alloc_tag), 32'(exp_tag));
      order_q.push_back(exp_tag);
      tick();
      alloc_valid = 0;
   endtask

   task automatic put_addr(input int tag, input logic [31:0] a, input bit track);
      addr_wr_valid = 1; addr_wr_tag = 3'(tag); addr_wr_value = a;
      if (track) exp_addr[tag] = a;
      tick();
      addr_wr_valid = 0;
   endtask

   task automatic put_data(input int tag, input logic [31:0] d, input bit track);
      data_wr_valid = 1; data_wr_tag = 3'(tag); data_wr_value = d;
      if (track) exp_data[tag] = d;
      tick();
      data_wr_valid = 0;
   endtask

   task automatic probe(input logic [31:0] a, input bit e_hit, input bit e_stall,
                        input logic [31:0] e_data, input string tagmsg);
      ld_valid = 1; ld_addr = a;
      #0.5;
      chk(ld_stall === e_stall, {tagmsg, " ld_stall"}, 32'(ld_stall), 32'(e_stall));
      chk(ld_hit === e_hit, {tagmsg, " ld_hit"}, 32'(ld_hit), 32'(e_hit));
      if (e_hit) chk(ld_data === e_data, {tagmsg, " ld_data"}, ld_data, e_data);
      ld_valid = 0;
   endtask

   task automatic issue_fence(input logic [1:0] k);
      fence_valid = 1; fence_kind = k;
      #0.1;
      chk(fence_ready === 1'b1, "R6 fence_ready when idle", 32'(fence_ready), 1);
      tick();
      fence_valid = 0;
   endtask

   task automatic wait_fence_done(output bit seen);
      seen = 0;
      for (int k = 0; k < 40 && !seen; k++) begin
         if (fence_done === 1'b1) seen = 1;
         else tick();
      end
   endtask

   // Monitor: pop the expected store and compare on every accepted commit.
   always @(negedge clk) begin
      if (!rst && cache_valid === 1'b1 && cache_ready === 1'b1) begin
         if (order_q.size() == 0) begin
            chk(0, "R3 unexpected commit", cache_addr, 0);
         end else begin
            int t;
            t = order_q.pop_front();
            chk(cache_addr === exp_addr[t], "R2 R3 commit address in order", cache_addr, exp_addr[t]);
            chk(cache_data === exp_data[t], "R2 R3 commit data in order", cache_data, exp_data[t]);
         end
         n_commits++;
      end
   end

   initial begin
      #1000000;
      chk(0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      bit seen;
      logic [31:0] held;
      int base;
      repeat (3) @(posedge clk);
      #1 rst = 0;

      // Reset state
      chk(alloc_ready === 1'b1, "R11 alloc_ready after reset", 32'(alloc_ready), 1);
      chk(cache_valid === 1'b0, "R11 cache_valid after reset", 32'(cache_valid), 0);
      chk(fence_ready === 1'b1, "R11 fence_ready after reset", 32'(fence_ready), 1);
      chk(alloc_tag === 3'd0, "R11 first tag", 32'(alloc_tag), 0);
      probe(32'h100, 0, 0, 0, "R11 empty lookup");

      // Allocation and out-of-order fills
      do_alloc(0); do_alloc(1); do_alloc(2);
      put_data(1, 32'h22, 1); put_addr(1, 32'h104, 1);
      put_addr(0, 32'h100, 1); put_data(0, 32'h11, 1);
      put_addr(2, 32'h100, 1);
      put_addr(0, 32'h999, 0);           // repeated field write, must be ignored
      chk(cache_valid === 1'b0, "R4 no commit without trigger", 32'(cache_valid), 0);
      probe(32'h100, 0, 1, 0, "R9 youngest match lacks data");
      put_data(2, 32'h33, 1);
      probe(32'h100, 1, 0, 32'h33, "R8 youngest match forwarded");
      probe(32'h104, 1, 0, 32'h22, "R8 single match forwarded");
      probe(32'h108, 0, 0, 0, "R9 miss without stall");
      do_alloc(3);
      probe(32'h108, 0, 1, 0, "R9 unknown address stalls");
      put_addr(3, 32'h108, 1);
      probe(32'h108, 0, 1, 0, "R9 match without data");
      put_data(3, 32'h44, 1);
      probe(32'h108, 1, 0, 32'h44, "R2 data after address forwarded");
      chk(cache_valid === 1'b0, "R4 still idle when complete", 32'(cache_valid), 0);

      // Store fence with back-pressure
      cache_ready = 0;
      issue_fence(2'd0);
      chk(cache_valid === 1'b1, "R6 store fence starts drain", 32'(cache_valid), 1);
      held = cache_addr;
      tick(); tick();
      chk(cache_valid === 1'b1, "R5 valid held under back-pressure", 32'(cache_valid), 1);
      chk(cache_addr === held, "R5 head stable under back-pressure", cache_addr, held);
      chk(fence_done === 1'b0, "R6 no done before commits", 32'(fence_done), 0);
      probe(32'h500, 0, 0, 0, "R6 loads not blocked by store fence");
      cache_ready = 1;
      wait_fence_done(seen);
      chk(seen, "R6 fence_done observed", 32'(seen), 1);
      chk(n_commits == 4, "R6 all older stores committed at done", 32'(n_commits), 4);
      tick();
      chk(fence_ready === 1'b1, "R6 fence_ready after done", 32'(fence_ready), 1);

      // Full fence, incomplete head blocks younger complete entry
      do_alloc(4); do_alloc(5);
      put_addr(5, 32'h540, 1); put_data(5, 32'h55, 1);
      put_addr(4, 32'h500, 1);
      issue_fence(2'd1);
      probe(32'h700, 0, 1, 0, "R7 full fence blocks loads");
      chk(cache_valid === 1'b0, "R3 incomplete head blocks commit", 32'(cache_valid), 0);
      tick(); tick();
      chk(cache_valid === 1'b0, "R3 head still blocking", 32'(cache_valid), 0);
      put_data(4, 32'h45, 1);
      wait_fence_done(seen);
      chk(seen, "R7 full fence done observed", 32'(seen), 1);
      chk(n_commits == 6, "R7 commits at done", 32'(n_commits), 6);
      probe(32'h700, 0, 1, 0, "R7 loads blocked in done cycle");
      tick();
      probe(32'h700, 0, 0, 0, "R7 loads released after done");

      // Full-buffer drain
      for (int i = 0; i < 8; i++) do_alloc((6 + i) % 8);
      chk(alloc_ready === 1'b0, "R1 alloc_ready low when full", 32'(alloc_ready), 0);
      chk(cache_valid === 1'b0, "R4 full but head incomplete", 32'(cache_valid), 0);
      put_addr(7, 32'h770, 1); put_data(7, 32'h77, 1);
      put_addr(6, 32'h660, 1);
      base = n_commits;
      put_data(6, 32'h66, 1);
      chk(cache_valid === 1'b1, "R4 full buffer drains", 32'(cache_valid), 1);
      tick();
      chk(n_commits == base + 1, "R4 one commit from full drain", 32'(n_commits), 32'(base + 1));
      chk(cache_valid === 1'b0, "R4 drain stops below full", 32'(cache_valid), 0);
      chk(alloc_ready === 1'b1, "R1 alloc_ready after slot frees", 32'(alloc_ready), 1);

      // Exception: tags 7,0 complete at head, tag 1 incomplete
      put_addr(0, 32'h600, 1); put_data(0, 32'h60, 1);
      put_addr(1, 32'h610, 1);
      put_addr(2, 32'h620, 1); put_data(2, 32'h62, 1);
      order_q = order_q[0:1];
      base = n_commits;
      exc_req = 1; tick(); exc_req = 0;
      chk(alloc_ready === 1'b0, "R1 alloc blocked during exception", 32'(alloc_ready), 0);
      seen = 0;
      for (int k = 0; k < 40 && !seen; k++) begin
         if (exc_done === 1'b1) seen = 1;
         else tick();
      end
      chk(seen, "R10 exc_done observed", 32'(seen), 1);
      chk(n_commits == base + 2, "R10 complete head stores committed", 32'(n_commits), 32'(base + 2));
      tick();
      put_data(1, 32'hdead, 0);          // to a discarded slot, must be ignored
      probe(32'h620, 0, 0, 0, "R10 discarded store not forwarded");
      probe(32'h610, 0, 0, 0, "R2 fill to discarded slot ignored");
      do_alloc(1);
      put_addr(1, 32'h710, 1); put_data(1, 32'h71, 1);
      base = n_commits;
      issue_fence(2'd2);
      probe(32'h800, 0, 1, 0, "R7 serialization blocks loads");
      wait_fence_done(seen);
      chk(seen, "R7 serialization done", 32'(seen), 1);
      chk(n_commits == base + 1, "R10 reused slot commits", 32'(n_commits), 32'(base + 1));
      tick();
      chk(order_q.size() == 0, "R3 all expected stores committed", 32'(order_q.size()), 0);
      finish_run();
   end
endmodule